// File: doc/BRIEF.md
# Shared Adder-XOR Rotating ALU

This block is the arithmetic core of a compact add-rotate-XOR mixing engine. It holds two operand registers (R1, R2), a result register (R3) and a three-stage left-rotation pipe (R4, R5, R6). A single operation bit picks between a modular addition of R1 and R2 and an exclusive OR of R3 with R6. Both operations are produced by one carry chain: the sum of `a OR b` and `(a AND b)` optionally inverted, plus a carry-in equal to the operation bit. That expression yields `a + b` when the bit is 0 and `a XOR b` when it is 1.

An external sequencer steers the block cycle by cycle. It sets a separate enable for every register, picks where R1 and R2 load from (read port A, read port B, or R3 fed back), and gives a 2-bit rotate amount for each pipe stage. A mixing step loads the word to be rotated into R1 and the pipe in the same cycle. The second operand then enters R2 while R1 holds. The sum lands in R3 on the same edge that the rotated word reaches R6, and the XOR follows on the next edge.

Top module: `mix_alu`

## Requirements
- R1: When `rst` is high at a clock edge, R1 to R6 all become zero, so `result` and `rot_out` read zero afterwards.
- R2: With `en_r3=1` and `op_xor=0`, R3 takes (R1 + R2) mod 2^64 at the next edge.
- R3: With `en_r3=1` and `op_xor=1`, R3 takes R3 XOR R6 at the next edge.
- R4: The rotation pipe feeds `port_a` into R4, R4 into R5 and R5 into R6. Stage s (0, 1, 2) rotates its input left by `rot_sel[2s+1:2s]` times 4^s when `rot_en[s]` is 1. Holding `rot_sel=k` while pulsing `rot_en` bits 0, 1, 2 on three consecutive edges leaves rotl(x, k) in R6, for any k in 0..63.
- R5: A register whose enable is 0 keeps its value. In particular, R1 holds while R2 loads and `port_a` changes.
- R6: R2 loads from `port_a` when `r2_from_b=0`, from `port_b` when `r2_from_b=1`, and from R3 whenever `r2_from_r3=1`, which overrides `r2_from_b`.
- R7: R1 loads from `port_a` when `r1_from_r3=0` and from R3 when `r1_from_r3=1`.
- R8: The four-edge mix order is as follows. Edge 1 loads R1 and R4 from `port_a`. Edge 2 loads R2 and advances to R5. Edge 3 adds into R3 and advances to R6. Edge 4 does the XOR. This leaves (e0 + e1) XOR rotl(e1, k) in R3.
- R9: Two stored words x and y can be combined by exclusive OR alone. Store x in R3 by adding zero, pass y through the pipe with rotate amount 0, then apply the XOR. R3 then reads x XOR y.
- R10: With `en_r3=0`, R3 is unchanged whatever `op_xor` and the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_a | input | 64 | First read-port word (R1, R2 and rotation pipe source) |
| port_b | input | 64 | Second read-port word (R2 source) |
| op_xor | input | 1 | 0: R3 gets R1+R2; 1: R3 gets R3 XOR R6 |
| r1_from_r3 | input | 1 | R1 loads R3 instead of port_a |
| r2_from_b | input | 1 | R2 loads port_b instead of port_a |
| r2_from_r3 | input | 1 | R2 loads R3 (overrides r2_from_b) |
| en_r1 | input | 1 | R1 load enable |
| en_r2 | input | 1 | R2 load enable |
| en_r3 | input | 1 | R3 load enable |
| rot_en | input | 3 | Load enables for R4, R5, R6 (bit s = stage s) |
| rot_sel | input | 6 | Rotate amount; bits [2s+1:2s] are used by stage s |
| result | output | 64 | R3 |
| rot_out | output | 64 | R6 |

## Verification
Two of this block's functions coincide on one edge. The addition that writes R3 falls on the same edge as the final rotation stage that writes R6, and the XOR on the next edge must see the freshly written R6 rather than its old value. The bench provokes this by running the full mix order with random words and with rotate amounts 0, 63 and random values. It judges R3 after the add edge against the modular sum and after the XOR edge against the sum XOR the rotated word, both computed in the bench. A second overlap, R2 loading from a port while R1 holds and the port changes, is judged through the later sum.

// File: rtl/mix_alu_pkg.sv
package mix_alu_pkg;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_XOR = 1'b1
  } alu_op_e;

  // Rotate distance of one pipe stage: 2-bit select scaled by 4^stage.
  function automatic int stage_shift(input int stage, input logic [1:0] sel);
    return int'(sel) << (2 * stage);
  endfunction

endpackage

// File: rtl/mix_shared_adder.sv
module mix_shared_adder #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         op,
  output logic [W-1:0] sum
);
  logic [W-1:0] or_t;
  logic [W-1:0] and_t;
  logic [W-1:0] cin;

  // a|b + (a&b) = a+b ; a|b + ~(a&b) + 1 = a|b - a&b = a^b
  always_comb begin
    or_t  = a | b;
    and_t = (a & b) ^ {W{op}};
    cin   = {{(W-1){1'b0}}, op};
    sum   = or_t + and_t + cin;
  end

  always_comb begin
    if (op == 1'b0) begin
      a_r2_add_identity: assert (sum == a + b);
    end else begin
      a_r3_xor_identity: assert (sum == (a ^ b));
    end
  end

endmodule

// File: rtl/mix_rot_stage.sv
module mix_rot_stage
  import mix_alu_pkg::*;
#(
  parameter int W     = 64,
  parameter int STAGE = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [1:0]   sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  int unsigned  amt;
  logic [W-1:0] rotated;

  always_comb begin
    amt     = unsigned'(stage_shift(STAGE, sel)) % W;
    rotated = (amt == 0) ? d : ((d << amt) | (d >> (W - amt)));
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= rotated;
  end

  // R4: loaded value is the input rotated by the scaled select
  property p_rot_load;
    @(posedge clk) disable iff (rst)
      (en) |=> (q == (($past(d) << (($past(int'(sel)) << (2*STAGE)) % W)) |
                      ((($past(int'(sel)) << (2*STAGE)) % W == 0) ? '0 :
                       ($past(d) >> (W - (($past(int'(sel)) << (2*STAGE)) % W))))));
  endproperty
  a_r4_stage_rotates: assert property (p_rot_load);

  // R5: disabled stage keeps its word
  a_r5_stage_holds: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (q == $past(q)));

endmodule

// File: rtl/mix_alu.sv
module mix_alu
  import mix_alu_pkg::*;
#(
  parameter int W = 64,
  localparam int ROT_W  = $clog2(W),
  localparam int NSTAGE = (ROT_W + 1) / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          port_a,
  input  logic [W-1:0]          port_b,
  input  logic                  op_xor,
  input  logic                  r1_from_r3,
  input  logic                  r2_from_b,
  input  logic                  r2_from_r3,
  input  logic                  en_r1,
  input  logic                  en_r2,
  input  logic                  en_r3,
  input  logic [NSTAGE-1:0]     rot_en,
  input  logic [2*NSTAGE-1:0]   rot_sel,
  output logic [W-1:0]          result,
  output logic [W-1:0]          rot_out
);
  logic [W-1:0] r1_q, r2_q, r3_q;
  logic [W-1:0] r1_d, r2_d;
  logic [W-1:0] opnd_a, opnd_b, alu_sum;
  logic [W-1:0] pipe [0:NSTAGE];
  alu_op_e      op;

  assign op = alu_op_e'(op_xor);

  // operand sources, including R3 bypass
  always_comb begin
    r1_d = r1_from_r3 ? r3_q : port_a;
    if (r2_from_r3)     r2_d = r3_q;
    else if (r2_from_b) r2_d = port_b;
    else                r2_d = port_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_q <= '0;
      r2_q <= '0;
      r3_q <= '0;
    end else begin
      if (en_r1) r1_q <= r1_d;
      if (en_r2) r2_q <= r2_d;
      if (en_r3) r3_q <= alu_sum;
    end
  end

  // rotation pipe: port_a -> R4 -> R5 -> R6
  assign pipe[0] = port_a;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_rot
    mix_rot_stage #(.W(W), .STAGE(s)) u_stage (
      .clk (clk),
      .rst (rst),
      .en  (rot_en[s]),
      .sel (rot_sel[2*s +: 2]),
      .d   (pipe[s]),
      .q   (pipe[s+1])
    );
  end

  // one control bit picks both the operand pair and the function
  always_comb begin
    if (op == ALU_XOR) begin
      opnd_a = r3_q;
      opnd_b = pipe[NSTAGE];
    end else begin
      opnd_a = r1_q;
      opnd_b = r2_q;
    end
  end

  mix_shared_adder #(.W(W)) u_adder (
    .a   (opnd_a),
    .b   (opnd_b),
    .op  (op_xor),
    .sum (alu_sum)
  );

  assign result  = r3_q;
  assign rot_out = pipe[NSTAGE];

  // R1: reset clears every register
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (r1_q == '0 && r2_q == '0 && r3_q == '0 && rot_out == '0));

  // R2: add lands in R3 one edge later
  a_r2_sum_lands: assert property (@(posedge clk) disable iff (rst)
    (en_r3 && !op_xor) |=> (r3_q == $past(r1_q + r2_q)));

  // R3: xor lands in R3 one edge later
  a_r3_xor_lands: assert property (@(posedge clk) disable iff (rst)
    (en_r3 && op_xor) |=> (r3_q == ($past(r3_q) ^ $past(rot_out))));

  // R5: R1 holds without its enable
  a_r5_r1_holds: assert property (@(posedge clk) disable iff (rst)
    (!en_r1) |=> (r1_q == $past(r1_q)));

  // R10: R3 holds without its enable
  a_r10_r3_holds: assert property (@(posedge clk) disable iff (rst)
    (!en_r3) |=> $stable(r3_q));

endmodule

// File: tb/mix_alu_bench.sv
module mix_alu_bench;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] port_a, port_b;
  logic         op_xor, r1_from_r3, r2_from_b, r2_from_r3;
  logic         en_r1, en_r2, en_r3;
  logic [2:0]   rot_en;
  logic [5:0]   rot_sel;
  logic [W-1:0] result, rot_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mix_alu #(.W(W)) u_mix_alu (
    .clk(clk), .rst(rst), .port_a(port_a), .port_b(port_b),
    .op_xor(op_xor), .r1_from_r3(r1_from_r3), .r2_from_b(r2_from_b),
    .r2_from_r3(r2_from_r3), .en_r1(en_r1), .en_r2(en_r2), .en_r3(en_r3),
    .rot_en(rot_en), .rot_sel(rot_sel), .result(result), .rot_out(rot_out)
  );

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int k);
    if (k == 0) return x;
    return (x << k) | (x >> (W - k));
  endfunction

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    port_a = '0; port_b = '0; op_xor = 0; r1_from_r3 = 0; r2_from_b = 0;
    r2_from_r3 = 0; en_r1 = 0; en_r2 = 0; en_r3 = 0; rot_en = '0; rot_sel = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  // R3 <- v via v + 0
  task automatic set_r3(input logic [W-1:0] v);
    port_a = v; port_b = '0; en_r1 = 1; en_r2 = 1; r2_from_b = 1; tick();
    en_r3 = 1; op_xor = 0; tick();
  endtask

  task automatic rotate(input logic [W-1:0] x, input int k);
    port_a = x; rot_sel = 6'(k); rot_en = 3'b001; tick();
    rot_sel = 6'(k); rot_en = 3'b010; tick();
    rot_sel = 6'(k); rot_en = 3'b100; tick();
  endtask

  task automatic t_reset();
    chk("R1 result after reset", result, '0);
    chk("R1 rot_out after reset", rot_out, '0);
  endtask

  task automatic t_add();
    logic [W-1:0] xs [4];
    logic [W-1:0] ys [4];
    xs[0] = '1;          ys[0] = 64'd1;
    xs[1] = '1;          ys[1] = '1;
    xs[2] = rnd64();     ys[2] = rnd64();
    xs[3] = 64'h8000_0000_0000_0000; ys[3] = 64'h8000_0000_0000_0001;
    for (int i = 0; i < 4; i++) begin
      port_a = xs[i]; port_b = ys[i]; en_r1 = 1; en_r2 = 1; r2_from_b = 1; tick();
      en_r3 = 1; tick();
      chk("R2 modular add", result, xs[i] + ys[i]);
    end
  endtask

  task automatic t_rot_all();
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] x;
      x = rnd64();
      rotate(x, k);
      chk($sformatf("R4 rotl by %0d", k), rot_out, rotl(x, k));
    end
  endtask

  task automatic t_xor_stored();
    logic [W-1:0] x, y;
    x = rnd64(); y = rnd64();
    set_r3(x);
    rotate(y, 0);
    op_xor = 1; en_r3 = 1; tick();
    chk("R9 xor of stored words", result, x ^ y);
    rotate(64'h0123_4567_89ab_cdef, 8);
    op_xor = 1; en_r3 = 1; tick();
    chk("R3 xor with rotated R6", result, x ^ y ^ rotl(64'h0123_4567_89ab_cdef, 8));
  endtask

  task automatic t_hold();
    logic [W-1:0] x, y, v;
    x = rnd64(); y = rnd64();
    port_a = x; en_r1 = 1; tick();
    port_a = y; en_r2 = 1; tick();           // R1 must keep x
    port_a = rnd64(); tick();                // nothing enabled
    en_r3 = 1; tick();
    chk("R5 R1 held while R2 loaded", result, x + y);
    v = result;
    rotate(rnd64(), 5);
    port_a = rnd64(); port_b = rnd64(); en_r1 = 1; en_r2 = 1; r2_from_b = 1; op_xor = 1; tick();
    chk("R10 R3 held with op_xor=1", result, v);
    op_xor = 0; tick();
    chk("R10 R3 held with op_xor=0", result, v);
  endtask

  task automatic t_sources();
    logic [W-1:0] v, w, x;
    v = rnd64(); w = rnd64(); x = rnd64();
    set_r3(v);
    port_a = rnd64(); port_b = w; r1_from_r3 = 1; en_r1 = 1; en_r2 = 1; r2_from_b = 1; tick();
    en_r3 = 1; tick();
    chk("R7 R1 bypass from R3", result, v + w);
    set_r3(v);
    port_a = x; port_b = rnd64(); en_r1 = 1; en_r2 = 1; r2_from_b = 1; r2_from_r3 = 1; tick();
    en_r3 = 1; tick();
    chk("R6 R2 from R3 overrides port_b", result, x + v);
    port_a = x; port_b = w; en_r2 = 1; r2_from_b = 0; tick();
    en_r3 = 1; tick();
    chk("R6 R2 from port_a", result, x + x);
  endtask

  task automatic t_mix(input int k);
    logic [W-1:0] e0, e1;
    e0 = rnd64(); e1 = rnd64();
    port_a = e1; en_r1 = 1; rot_en = 3'b001; rot_sel = 6'(k); tick();
    port_a = rnd64(); port_b = e0; r2_from_b = 1; en_r2 = 1; rot_en = 3'b010; rot_sel = 6'(k); tick();
    en_r3 = 1; rot_en = 3'b100; rot_sel = 6'(k); tick();
    chk($sformatf("R8 mix add k=%0d", k), result, e0 + e1);
    op_xor = 1; en_r3 = 1; tick();
    chk($sformatf("R8 mix xor k=%0d", k), result, (e0 + e1) ^ rotl(e1, k));
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_rot_all();
    t_xor_stored();
    t_hold();
    t_sources();
    t_mix(0);
    t_mix(63);
    for (int i = 0; i < 6; i++) t_mix(int'($urandom_range(1, 62)));
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule